// File: doc/BRIEF.md
# Register-Controlled Clock Routing Crossbar

This block is the low-address control register file on a front-end card. It decodes a simple register bus with a 12-bit address, 16-bit data and separate read and write strobes. It answers only inside its own address window. All other addresses are left to the downstream FPGA.

The central register holds four 4-bit source selectors. Each selector picks one of the sources (the internal oscillator, four external clocks, a software-toggled bit, two FPGA-driven lines, or the two front-panel port pins) and routes it onto one of four outputs. The outputs are a primary global clock, a secondary global clock and two front-panel clock outputs. Routing is a plain combinational multiplexer.

The block also holds the following:
- a register of software clock bits;
- a direction mode and an output latch for a 2-bit bidirectional front-panel port, with readback of the pin levels;
- a control register with a reset-request bit and an LED-test bit;
- a guarded system-reset register.

Top module: `clock_route_xbar`

## Requirements
- R1: The block claims a bus access only when address bits [11:8] are zero. For any other address, `busClaim` is 0, `busRdData` is 0 and a write changes no register. Inside the window the register index is address bits [7:0].
- R2: Index 1 holds four select fields. Bits [3:0] steer `clkPrimary`, [7:4] steer `clkSecondary`, [11:8] steer `clkPanel[0]` and [15:12] steer `clkPanel[1]`. The source codes are: 0 = `oscClk`, 1..4 = `extClk[0..3]`, 5 = that output's software bit, 6..7 = `fpgaLine[0..1]`, 8..9 = `portPadIn[0..1]`.
- R3: Index 2 holds software clock bits. Bit 0 belongs to the primary clock, bit 1 to the secondary clock, bit 2 to panel output 0 and bit 3 to panel output 1. An output on code 5 follows its own bit.
- R4: Select codes 10 to 15 drive the output to constant 0.
- R5: Index 6 bits [1:0] set the port mode. With bit 1 at 0 (codes 00 and 01), `portPadOe` and `portPadOut` come from `fpgaPortDir` and `fpgaPortOut`. Code 10 drives `portPadOe` to 00. Code 11 drives `portPadOe` to 11, and `portPadOut` then comes from the latch.
- R6: Index 4 bits [1:0] are the port output latch. Reading index 5 returns `portPadIn` in bits [1:0].
- R7: Index 0 bit 0 drives `resetReq` and bit 1 drives `ledTest`.
- R8: A write of exactly 16'h0000 to index 63 raises `sysResetPulse` for one cycle, in the cycle after the write edge. A write of any other value to index 63 leaves it low.
- R9: After reset, all select fields, software bits, the latch, index 0 and the port mode are 0.
- R10: Reads of indices 0, 1, 2, 4 and 6 return the last value written, in the register's own width. Reads of any other index inside the window return 0. Read data is combinational while `busRd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Bus address |
| busWrData | input | 16 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdData | output | 16 | Read data (0 when not claimed) |
| busClaim | output | 1 | Address lies in this block's window |
| oscClk | input | 1 | Internal oscillator |
| extClk | input | 4 | External clock inputs |
| fpgaLine | input | 2 | FPGA-driven clock lines |
| fpgaPortDir | input | 2 | FPGA-side port drive enables |
| fpgaPortOut | input | 2 | FPGA-side port output data |
| portPadIn | input | 2 | Front-panel port pin levels |
| portPadOut | output | 2 | Front-panel port output data |
| portPadOe | output | 2 | Front-panel port drive enable, 1 = drive |
| clkPrimary | output | 1 | Primary global clock |
| clkSecondary | output | 1 | Secondary global clock |
| clkPanel | output | 2 | Front-panel clock outputs |
| resetReq | output | 1 | Reset request bit |
| ledTest | output | 1 | LED test bit |
| sysResetPulse | output | 1 | One-cycle system reset |

## Verification
Every output is driven through all sixteen select codes. Meanwhile the other three fields hold random codes and all source levels are random. This separates a wrong field position, a swapped source index and a shared software bit. Every rep repeats with fresh source levels, so a code stuck to the wrong source shows up as a mismatch on one of the random levels. Directed cases cover four areas:
- writes just outside the window, which must leave the selects unchanged;
- each port mode code with opposing FPGA-side and latch values, so the mux choice is visible;
- system-reset writes of zero against a single set bit;
- reads of unused indices inside the window.

// File: rtl/clock_route_pkg.sv
package clock_route_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 16;
  localparam int SEL_W   = 4;
  localparam int N_OUT   = 4;
  localparam int N_EXT   = 4;
  localparam int PORT_W  = 2;
  localparam int N_SRC   = 1 << SEL_W;
  localparam int IDX_W   = 8;
  localparam int WIN_LO  = IDX_W;

  localparam logic [IDX_W-1:0] REG_CTL   = 8'd0;
  localparam logic [IDX_W-1:0] REG_SEL   = 8'd1;
  localparam logic [IDX_W-1:0] REG_SW    = 8'd2;
  localparam logic [IDX_W-1:0] REG_LATCH = 8'd4;
  localparam logic [IDX_W-1:0] REG_PIN   = 8'd5;
  localparam logic [IDX_W-1:0] REG_MODE  = 8'd6;
  localparam logic [IDX_W-1:0] REG_SYS   = 8'd63;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTL, RD_SEL, RD_SW, RD_LATCH, RD_PIN, RD_MODE
  } rdSrc_e;

  typedef struct packed {
    logic   claim;
    logic   wrCtl;
    logic   wrSel;
    logic   wrSw;
    logic   wrLatch;
    logic   wrMode;
    logic   fireSys;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;
endpackage

// File: rtl/clock_route_ctrl.sv
module clock_route_ctrl
  import clock_route_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  output ctrlStrobe_t       strobe
);
  logic [IDX_W-1:0] regIdx;
  logic             inWindow;

  assign regIdx   = busAddr[IDX_W-1:0];
  assign inWindow = (busAddr[ADDR_W-1:WIN_LO] == '0);

  always_comb begin
    strobe         = '0;
    strobe.rdSrc   = RD_NONE;
    strobe.claim   = inWindow;
    if (inWindow) begin
      unique case (regIdx)
        REG_CTL:   strobe.rdSrc = RD_CTL;
        REG_SEL:   strobe.rdSrc = RD_SEL;
        REG_SW:    strobe.rdSrc = RD_SW;
        REG_LATCH: strobe.rdSrc = RD_LATCH;
        REG_PIN:   strobe.rdSrc = RD_PIN;
        REG_MODE:  strobe.rdSrc = RD_MODE;
        default:   strobe.rdSrc = RD_NONE;
      endcase
      strobe.wrCtl   = busWr && (regIdx == REG_CTL);
      strobe.wrSel   = busWr && (regIdx == REG_SEL);
      strobe.wrSw    = busWr && (regIdx == REG_SW);
      strobe.wrLatch = busWr && (regIdx == REG_LATCH);
      strobe.wrMode  = busWr && (regIdx == REG_MODE);
      strobe.fireSys = busWr && (regIdx == REG_SYS) && (busWrData == '0);
    end
  end
endmodule

// File: rtl/clock_source_mux.sv
module clock_source_mux
  import clock_route_pkg::*;
(
  input  logic [N_SRC-1:0] srcVec,
  input  logic [SEL_W-1:0] sel,
  output logic             routed
);
  assign routed = srcVec[sel];
endmodule

// File: rtl/clock_route_dpath.sv
module clock_route_dpath
  import clock_route_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  input  logic              oscClk,
  input  logic [N_EXT-1:0]  extClk,
  input  logic [1:0]        fpgaLine,
  input  logic [PORT_W-1:0] fpgaPortDir,
  input  logic [PORT_W-1:0] fpgaPortOut,
  input  logic [PORT_W-1:0] portPadIn,
  output logic [PORT_W-1:0] portPadOut,
  output logic [PORT_W-1:0] portPadOe,
  output logic [N_OUT-1:0]  routedClk,
  output logic              resetReq,
  output logic              ledTest,
  output logic              sysResetPulse
);
  localparam int SEL_TOT = SEL_W * N_OUT;
  localparam int USED    = 10;

  logic [1:0]        ctlReg;
  logic [SEL_TOT-1:0] selReg;
  logic [N_OUT-1:0]  swReg;
  logic [PORT_W-1:0] latchReg;
  logic [1:0]        modeReg;
  logic              sysPulseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg    <= '0;
      selReg    <= '0;
      swReg     <= '0;
      latchReg  <= '0;
      modeReg   <= '0;
      sysPulseQ <= 1'b0;
    end else begin
      if (strobe.wrCtl)   ctlReg   <= busWrData[1:0];
      if (strobe.wrSel)   selReg   <= busWrData[SEL_TOT-1:0];
      if (strobe.wrSw)    swReg    <= busWrData[N_OUT-1:0];
      if (strobe.wrLatch) latchReg <= busWrData[PORT_W-1:0];
      if (strobe.wrMode)  modeReg  <= busWrData[1:0];
      sysPulseQ <= strobe.fireSys;
    end
  end

  assign resetReq      = ctlReg[0];
  assign ledTest       = ctlReg[1];
  assign sysResetPulse = sysPulseQ;

  // Port mode: bit 1 clear hands the port to the FPGA side.
  always_comb begin
    if (modeReg[1]) begin
      portPadOe  = {PORT_W{modeReg[0]}};
      portPadOut = latchReg;
    end else begin
      portPadOe  = fpgaPortDir;
      portPadOut = fpgaPortOut;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_route
      logic [N_SRC-1:0] srcVec;
      always_comb begin
        srcVec             = '0;
        srcVec[0]          = oscClk;
        srcVec[N_EXT:1]    = extClk;
        srcVec[5]          = swReg[g];
        srcVec[7:6]        = fpgaLine;
        srcVec[USED-1:8]   = portPadIn;
      end
      clock_source_mux mux_i (
        .srcVec (srcVec),
        .sel    (selReg[g*SEL_W +: SEL_W]),
        .routed (routedClk[g])
      );
    end
  endgenerate

  always_comb begin
    busRdData = '0;
    if (busRd && strobe.claim) begin
      unique case (strobe.rdSrc)
        RD_CTL:   busRdData[1:0]         = ctlReg;
        RD_SEL:   busRdData[SEL_TOT-1:0] = selReg;
        RD_SW:    busRdData[N_OUT-1:0]   = swReg;
        RD_LATCH: busRdData[PORT_W-1:0]  = latchReg;
        RD_PIN:   busRdData[PORT_W-1:0]  = portPadIn;
        RD_MODE:  busRdData[1:0]         = modeReg;
        default:  busRdData              = '0;
      endcase
    end
  end
endmodule

// File: rtl/clock_route_xbar.sv
module clock_route_xbar
  import clock_route_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  output logic              busClaim,
  input  logic              oscClk,
  input  logic [N_EXT-1:0]  extClk,
  input  logic [1:0]        fpgaLine,
  input  logic [PORT_W-1:0] fpgaPortDir,
  input  logic [PORT_W-1:0] fpgaPortOut,
  input  logic [PORT_W-1:0] portPadIn,
  output logic [PORT_W-1:0] portPadOut,
  output logic [PORT_W-1:0] portPadOe,
  output logic              clkPrimary,
  output logic              clkSecondary,
  output logic [1:0]        clkPanel,
  output logic              resetReq,
  output logic              ledTest,
  output logic              sysResetPulse
);
  ctrlStrobe_t        strobe;
  logic [N_OUT-1:0]   routedClk;

  clock_route_ctrl ctrl_i (
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .strobe    (strobe)
  );

  clock_route_dpath dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .busWrData     (busWrData),
    .busRd         (busRd),
    .busRdData     (busRdData),
    .oscClk        (oscClk),
    .extClk        (extClk),
    .fpgaLine      (fpgaLine),
    .fpgaPortDir   (fpgaPortDir),
    .fpgaPortOut   (fpgaPortOut),
    .portPadIn     (portPadIn),
    .portPadOut    (portPadOut),
    .portPadOe     (portPadOe),
    .routedClk     (routedClk),
    .resetReq      (resetReq),
    .ledTest       (ledTest),
    .sysResetPulse (sysResetPulse)
  );

  assign busClaim     = strobe.claim;
  assign clkPrimary   = routedClk[0];
  assign clkSecondary = routedClk[1];
  assign clkPanel     = routedClk[3:2];
endmodule

// File: rtl/clock_route_xbar_chk.sv
module clock_route_xbar_chk
  import clock_route_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdData,
  input logic              busClaim,
  input logic [PORT_W-1:0] portPadOe,
  input logic              sysResetPulse
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R1: outside the window nothing is claimed and reads return 0
  a_r1_no_claim: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:WIN_LO] != '0) |-> (!busClaim && busRdData == '0));

  // R8: a pulse needs a zero-data write to index 63 one edge earlier
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && sysResetPulse) |->
      $past(busWr && busAddr == 12'h03F && busWrData == '0));

  // R8: non-zero data to index 63 never fires
  a_r8_guard: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 12'h03F && busWrData != '0) |=> !sysResetPulse);

  // R8: pulse lasts one cycle without a repeated write
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (sysResetPulse && !busWr) |=> !sysResetPulse);

  // R5: forced output mode drives both pins
  a_r5_force_out: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 12'h006 && busWrData[1:0] == 2'b11) |=> (portPadOe == 2'b11));

  // R5: forced input mode releases both pins
  a_r5_force_in: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 12'h006 && busWrData[1:0] == 2'b10) |=> (portPadOe == 2'b00));

  // R10: reads with busRd low return 0
  a_r10_idle_rd: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdData == '0));
endmodule

bind clock_route_xbar clock_route_xbar_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .busAddr       (busAddr),
  .busWrData     (busWrData),
  .busWr         (busWr),
  .busRd         (busRd),
  .busRdData     (busRdData),
  .busClaim      (busClaim),
  .portPadOe     (portPadOe),
  .sysResetPulse (sysResetPulse)
);

// File: tb/clock_route_xbar_tb_top.sv
module clock_route_xbar_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] busAddr;
  logic [15:0] busWrData;
  logic        busWr, busRd;
  logic [15:0] busRdData;
  logic        busClaim;
  logic        oscClk;
  logic [3:0]  extClk;
  logic [1:0]  fpgaLine, fpgaPortDir, fpgaPortOut, portPadIn;
  logic [1:0]  portPadOut, portPadOe;
  logic        clkPrimary, clkSecondary;
  logic [1:0]  clkPanel;
  logic        resetReq, ledTest, sysResetPulse;

  int errCnt = 0;
  int chkCnt = 0;
  logic [15:0] modelSel;
  logic [3:0]  modelSw;

  always #2 clk = ~clk;

  clock_route_xbar dut_i (.*);

  initial begin
    #400000;
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    busRd = 1'b0;
  endtask

  function automatic logic srcModel(input logic [3:0] code, input int k);
    case (code)
      4'd0: return oscClk;
      4'd1, 4'd2, 4'd3, 4'd4: return extClk[code - 4'd1];
      4'd5: return modelSw[k];
      4'd6: return fpgaLine[0];
      4'd7: return fpgaLine[1];
      4'd8: return portPadIn[0];
      4'd9: return portPadIn[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkOutputs(input string req);
    logic [3:0] exp;
    for (int k = 0; k < 4; k++) exp[k] = srcModel(modelSel[k*4 +: 4], k);
    check(req, {12'd0, clkPanel, clkSecondary, clkPrimary}, {12'd0, exp});
  endtask

  initial begin
    logic [15:0] rd;
    void'($urandom(32'h5EED));
    rstN = 1'b0; busAddr = '0; busWrData = '0; busWr = 1'b0; busRd = 1'b0;
    oscClk = 1'b1; extClk = 4'h0; fpgaLine = 2'b00;
    fpgaPortDir = 2'b01; fpgaPortOut = 2'b10; portPadIn = 2'b01;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset values
    busRead(12'h001, rd); check("R9 sel reset", rd, 16'h0000);
    busRead(12'h002, rd); check("R9 sw reset", rd, 16'h0000);
    busRead(12'h006, rd); check("R9 mode reset", rd, 16'h0000);
    check("R9 primary on osc", {15'd0, clkPrimary}, 16'h0001);
    check("R9 port to fpga", {12'd0, portPadOe, portPadOut}, {12'd0, 2'b01, 2'b10});
    check("R9 ctl outputs", {14'd0, ledTest, resetReq}, 16'h0000);

    // R2 R3 R4: every code on every output with random neighbours
    for (int rep = 0; rep < 3; rep++) begin
      for (int k = 0; k < 4; k++) begin
        for (int code = 0; code < 16; code++) begin
          modelSel = 16'($urandom());
          modelSel[k*4 +: 4] = 4'(code);
          modelSw = 4'($urandom());
          busWrite(12'h001, modelSel);
          busWrite(12'h002, {12'd0, modelSw});
          oscClk = 1'($urandom()); extClk = 4'($urandom());
          fpgaLine = 2'($urandom()); portPadIn = 2'($urandom());
          #1;
          if (code >= 10) checkOutputs("R4 code above 9 gives 0");
          else if (code == 5) checkOutputs("R3 software bit");
          else checkOutputs("R2 source routing");
        end
      end
    end

    // R3: software edge on primary
    modelSel = 16'h0005; busWrite(12'h001, modelSel);
    modelSw = 4'h1; busWrite(12'h002, 16'h0001);
    check("R3 sw rise", {15'd0, clkPrimary}, 16'h0001);
    modelSw = 4'h0; busWrite(12'h002, 16'h0000);
    check("R3 sw fall", {15'd0, clkPrimary}, 16'h0000);

    // R10: readback
    busWrite(12'h001, 16'hA5C3); busRead(12'h001, rd); check("R10 sel readback", rd, 16'hA5C3);
    busWrite(12'h002, 16'hFFFA); busRead(12'h002, rd); check("R10 sw readback", rd, 16'h000A);
    busRead(12'h003, rd); check("R10 undefined index 3", rd, 16'h0000);
    busRead(12'h0C1, rd); check("R10 undefined index C1", rd, 16'h0000);

    // R1: outside the window
    busWrite(12'h101, 16'h1234); busRead(12'h001, rd); check("R1 no write outside", rd, 16'hA5C3);
    busWrite(12'hF06, 16'h0003); busRead(12'h006, rd); check("R1 mode untouched", rd, 16'h0000);
    @(negedge clk); busAddr = 12'h801; busRd = 1'b1; #1;
    check("R1 no claim", {busClaim, busRdData[14:0]}, 16'h0000);
    busRd = 1'b0;
    busAddr = 12'h0FF; #1; check("R1 claim inside", {15'd0, busClaim}, 16'h0001);

    // R5 R6: port modes
    busWrite(12'h004, 16'h0002);
    busRead(12'h004, rd); check("R6 latch readback", rd, 16'h0002);
    portPadIn = 2'b10; busRead(12'h005, rd); check("R6 pin readback", rd, 16'h0002);
    fpgaPortDir = 2'b10; fpgaPortOut = 2'b01;
    busWrite(12'h006, 16'h0003); #1;
    check("R5 forced out", {12'd0, portPadOe, portPadOut}, {12'd0, 2'b11, 2'b10});
    busWrite(12'h006, 16'h0002); #1;
    check("R5 forced in", {14'd0, portPadOe}, 16'h0000);
    busWrite(12'h006, 16'h0001); #1;
    check("R5 code 01 fpga", {12'd0, portPadOe, portPadOut}, {12'd0, 2'b10, 2'b01});
    busWrite(12'h006, 16'h0000); #1;
    check("R5 code 00 fpga", {12'd0, portPadOe, portPadOut}, {12'd0, 2'b10, 2'b01});

    // R7: control bits
    busWrite(12'h000, 16'h0001); check("R7 reset request", {14'd0, ledTest, resetReq}, 16'h0001);
    busWrite(12'h000, 16'h0002); check("R7 led test", {14'd0, ledTest, resetReq}, 16'h0002);

    // R8: guarded system reset
    busWrite(12'h03F, 16'h0000);
    check("R8 pulse on zero", {15'd0, sysResetPulse}, 16'h0001);
    @(negedge clk); check("R8 pulse one cycle", {15'd0, sysResetPulse}, 16'h0000);
    busWrite(12'h03F, 16'h0100);
    check("R8 nonzero ignored", {15'd0, sysResetPulse}, 16'h0000);
    busWrite(12'h13F, 16'h0000);
    check("R8 outside window ignored", {15'd0, sysResetPulse}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule